// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block resolves control flow for a 32-bit integer core. Each cycle it receives the current program counter, the two source register values, an offset that has already been sign-extended, and a control code that a decoder has produced. The code selects sequential flow, a PC-relative jump, a register-indirect jump, or one of six conditional branches. The block returns four results: the address to fetch next, a flag that says whether flow was redirected, the return address to write to the destination register, and a flag for a redirect target that is not word aligned.

All four results are registered, so they appear one clock after the inputs are sampled. Reset clears them. The unit does not act on the misalignment flag itself. It still presents the computed target with the taken flag high, and the surrounding core decides whether to trap.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: Every result appears exactly one clock after its inputs are sampled.
- R3: `link_o` is always the sampled PC plus 4, whatever the control code.
- R4: Control code 0 (sequential), and any code not listed in R5 to R9 (3 to 7, 10, 11), give next PC = PC+4 with `taken_o` low.
- R5: Code 1 (PC-relative jump) is always taken, with next PC = PC + offset. Offset bit 0 is treated as zero.
- R6: Code 2 (register-indirect jump) is always taken, with next PC = (rs1 + offset) with bit 0 cleared. The PC does not enter the target sum.
- R7: Code 8 is taken when rs1 equals rs2. Code 9 is taken when they differ.
- R8: Code 12 is taken when rs1 < rs2 as signed two's-complement values. Code 13 is taken when rs1 >= rs2 as signed values.
- R9: Code 14 is taken when rs1 < rs2 as unsigned values. Code 15 is taken when rs1 >= rs2 as unsigned values.
- R10: A taken branch goes to PC + offset, with offset bit 0 treated as zero. A branch that is not taken goes to PC+4.
- R11: `misalign_o` is high exactly when `taken_o` is high and bits [1:0] of the next PC are not both zero. The next PC still shows the computed target in that case.
- R12: A conditional branch that is not taken never raises `misalign_o`, even when its offset is not a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Current program counter |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| imm_i | input | 32 | Sign-extended offset |
| ctl_i | input | 4 | Control code (see R4 to R9) |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Flow was redirected |
| link_o | output | 32 | Return address, PC+4 |
| misalign_o | output | 1 | Redirect target is not 4-byte aligned |

## Verification
Operand pairs are chosen as equal, lower and higher values, and some of them straddle the sign boundary. One example is 0xFFFFFFFF against 1, which orders one way as a signed comparison and the other way as an unsigned one. This shows whether each comparison uses the correct signedness, and whether each inverted condition is the exact complement of its partner. Negative offsets and offsets with bits 0 or 1 set separate the relative targets from the absolute register-indirect target. They also check that bit 0 is cleared and that a misaligned target is flagged only when the redirect is actually taken. Random mixes of codes, including undefined codes, show that only the listed codes ever redirect flow.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN   = 32;
    localparam int CTLW   = 4;
    localparam int INSTB  = 4;   // bytes per instruction
    localparam int ALIGNW = 2;   // low address bits that must be zero

    typedef enum logic [CTLW-1:0] {
        CTL_SEQ  = 4'd0,
        CTL_JREL = 4'd1,
        CTL_JABS = 4'd2,
        CTL_BEQ  = 4'd8,
        CTL_BNE  = 4'd9,
        CTL_BLT  = 4'd12,
        CTL_BGE  = 4'd13,
        CTL_BLTU = 4'd14,
        CTL_BGEU = 4'd15
    } ctl_e;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_BAD = 2'b01,
        CMP_LTS = 2'b10,
        CMP_LTU = 2'b11
    } cmp_e;

    typedef struct packed {
        logic [XLEN-1:0] next_pc;
        logic            taken;
        logic [XLEN-1:0] link;
        logic            misalign;
    } npc_res_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] rel;
        logic [XLEN-1:0] abs;
    } npc_tgt_t;

    // Conditional branch codes: top bit set, compare-select field not CMP_BAD
    function automatic logic is_branch(input logic [CTLW-1:0] c);
        return c[CTLW-1] && (cmp_e'(c[2:1]) != CMP_BAD);
    endfunction

    function automatic logic is_misaligned(input logic [XLEN-1:0] a);
        return |a[ALIGNW-1:0];
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [CTLW-1:0] ctl,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic            take
);
    logic eq, lts, ltu, base;

    always_comb begin
        eq  = (a == b);
        lts = ($signed(a) < $signed(b));
        ltu = (a < b);
        unique case (cmp_e'(ctl[2:1]))
            CMP_EQ:  base = eq;
            CMP_LTS: base = lts;
            CMP_LTU: base = ltu;
            default: base = 1'b0;
        endcase
        // bit 0 selects the complementary condition (ne / ge / geu)
        take = is_branch(ctl) && (base ^ ctl[0]);
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] rs1,
    input  logic [W-1:0] imm,
    output npc_tgt_t     tgt
);
    logic [W-1:0] off_even;
    logic [W-1:0] abs_sum;

    always_comb begin
        off_even = {imm[W-1:1], 1'b0};
        abs_sum  = rs1 + imm;
        tgt.seq  = pc + W'(INSTB);
        tgt.rel  = pc + off_even;
        tgt.abs  = {abs_sum[W-1:1], 1'b0};
    end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    pc_i,
    input  logic [W-1:0]    rs1_i,
    input  logic [W-1:0]    rs2_i,
    input  logic [W-1:0]    imm_i,
    input  logic [CTLW-1:0] ctl_i,
    output logic [W-1:0]    next_pc_o,
    output logic            taken_o,
    output logic [W-1:0]    link_o,
    output logic            misalign_o
);
    npc_tgt_t tgt;
    logic     br_take;
    npc_res_t res_d, res_q;

    npc_cond #(.W(W)) cond_i (
        .ctl (ctl_i),
        .a   (rs1_i),
        .b   (rs2_i),
        .take(br_take)
    );

    npc_target #(.W(W)) tgt_i (
        .pc (pc_i),
        .rs1(rs1_i),
        .imm(imm_i),
        .tgt(tgt)
    );

    always_comb begin
        res_d.link    = tgt.seq;
        res_d.next_pc = tgt.seq;
        res_d.taken   = 1'b0;
        if (ctl_i == CTL_JREL) begin
            res_d.next_pc = tgt.rel;
            res_d.taken   = 1'b1;
        end else if (ctl_i == CTL_JABS) begin
            res_d.next_pc = tgt.abs;
            res_d.taken   = 1'b1;
        end else if (br_take) begin
            res_d.next_pc = tgt.rel;
            res_d.taken   = 1'b1;
        end
        res_d.misalign = res_d.taken && is_misaligned(res_d.next_pc);
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign next_pc_o  = res_q.next_pc;
    assign taken_o    = res_q.taken;
    assign link_o     = res_q.link;
    assign misalign_o = res_q.misalign;
endmodule

// File: rtl/npc_chk.sv
module npc_chk
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input logic            clk,
    input logic            rst,
    input logic [W-1:0]    pc_i,
    input logic [W-1:0]    rs1_i,
    input logic [CTLW-1:0] ctl_i,
    input logic [W-1:0]    next_pc_o,
    input logic            taken_o,
    input logic [W-1:0]    link_o,
    input logic            misalign_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (next_pc_o == '0 && !taken_o && link_o == '0 && !misalign_o));

    // R3
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> link_o == $past(pc_i) + W'(INSTB));

    // R4
    seq_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_i) == CTL_SEQ) |-> (!taken_o && next_pc_o == $past(pc_i) + W'(INSTB)));

    // R6
    abs_even_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_i) == CTL_JABS) |-> (taken_o && !next_pc_o[0]));

    // R10
    fallthru_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !taken_o) |-> next_pc_o == $past(pc_i) + W'(INSTB));

    // R11
    misalign_taken_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (taken_o && next_pc_o[1:0] != 2'b00));

    // R12
    nottaken_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> !misalign_o);
endmodule

bind next_pc_unit npc_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pc_i      (pc_i),
    .rs1_i     (rs1_i),
    .ctl_i     (ctl_i),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o),
    .link_o    (link_o),
    .misalign_o(misalign_o)
);

// File: tb/next_pc_unit_tb_top.sv
`timescale 1ns/1ps
module next_pc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, rs1_i = '0, rs2_i = '0, imm_i = '0;
    logic [3:0]  ctl_i = '0;
    logic [31:0] next_pc_o, link_o;
    logic        taken_o, misalign_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    next_pc_unit dut_i (
        .clk(clk), .rst(rst), .pc_i(pc_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
        .imm_i(imm_i), .ctl_i(ctl_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
        .link_o(link_o), .misalign_o(misalign_o)
    );

    typedef struct { logic [31:0] npc; logic tk; logic [31:0] lnk; logic mis; } exp_t;

    function automatic exp_t model(input logic [3:0] c, input logic [31:0] pc,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] imm);
        exp_t e;
        logic [31:0] s;
        logic t;
        e.lnk = pc + 32'd4;
        e.npc = pc + 32'd4;
        t = 1'b0;
        case (c)
            4'd1:  t = 1;
            4'd2:  t = 1;
            4'd8:  t = (a == b);
            4'd9:  t = (a != b);
            4'd12: t = ($signed(a) < $signed(b));
            4'd13: t = ($signed(a) >= $signed(b));
            4'd14: t = (a < b);
            4'd15: t = (a >= b);
            default: t = 0;
        endcase
        if (c == 4'd2) begin
            s = a + imm;
            e.npc = s & 32'hFFFF_FFFE;
        end else if (t) begin
            e.npc = pc + (imm & 32'hFFFF_FFFE);
        end
        e.tk = t;
        e.mis = t && (e.npc[1:0] != 2'b00);
        return e;
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1: return "R5";
            4'd2: return "R6";
            4'd8, 4'd9: return "R7";
            4'd12, 4'd13: return "R8";
            4'd14, 4'd15: return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge (R2), sample at next negedge
    task automatic run(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] imm);
        exp_t e;
        string r;
        ctl_i = c; pc_i = pc; rs1_i = a; rs2_i = b; imm_i = imm;
        e = model(c, pc, a, b, imm);
        r = req_of(c);
        @(negedge clk);
        chk(r, "taken", {31'd0, taken_o}, {31'd0, e.tk});
        chk(e.tk ? r : "R10", "next_pc", next_pc_o, e.npc);
        chk("R3", "link", link_o, e.lnk);
        chk(e.tk ? "R11" : "R12", "misalign", {31'd0, misalign_o}, {31'd0, e.mis});
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        ctl_i = 4'd2; pc_i = 32'h100; rs1_i = 32'h55;
        @(negedge clk); @(negedge clk);
        // R1: reset clears outputs
        chk("R1", "next_pc", next_pc_o, 32'd0);
        chk("R1", "taken", {31'd0, taken_o}, 32'd0);
        chk("R1", "link", link_o, 32'd0);
        chk("R1", "misalign", {31'd0, misalign_o}, 32'd0);
        rst = 1'b0;

        // R2: one-cycle latency, first result right after reset release
        run(4'd0, 32'h0000_1000, 0, 0, 0);
        // R4: unlisted codes never redirect
        run(4'd5, 32'h0000_2000, 1, 1, 32'h40);
        run(4'd10, 32'h0000_2000, 5, 5, 32'h40);
        // R5: relative jump, negative offset, odd bit ignored
        run(4'd1, 32'h0000_3000, 0, 0, 32'hFFFF_FFF0);
        run(4'd1, 32'h0000_3000, 0, 0, 32'h0000_0011);
        // R6: absolute target, odd low bit cleared, PC not used
        run(4'd2, 32'h0000_4000, 32'h0000_8001, 0, 32'h0000_0000);
        run(4'd2, 32'h0000_4000, 32'h0000_8000, 0, 32'hFFFF_FFFF);
        run(4'd2, 32'h0000_4000, 32'h0000_8000, 0, 32'h0000_0002); // R11 misaligned
        // R7
        run(4'd8, 32'h500, 32'h7, 32'h7, 32'h20);
        run(4'd8, 32'h500, 32'h7, 32'h8, 32'h20);
        run(4'd9, 32'h500, 32'h7, 32'h7, 32'h20);
        run(4'd9, 32'h500, 32'h7, 32'h8, 32'hFFFF_FFE0);
        // R8 / R9 across sign boundary: 0xFFFFFFFF vs 1
        run(4'd12, 32'h600, 32'hFFFF_FFFF, 32'h1, 32'h10);
        run(4'd13, 32'h600, 32'hFFFF_FFFF, 32'h1, 32'h10);
        run(4'd14, 32'h600, 32'hFFFF_FFFF, 32'h1, 32'h10);
        run(4'd15, 32'h600, 32'hFFFF_FFFF, 32'h1, 32'h10);
        run(4'd13, 32'h600, 32'h5, 32'h5, 32'h10);
        run(4'd15, 32'h600, 32'h5, 32'h5, 32'h10);
        // R11: taken branch to misaligned target still shows target
        run(4'd8, 32'h700, 1, 1, 32'h6);
        // R12: not-taken branch with misaligned offset
        run(4'd8, 32'h700, 1, 2, 32'h6);
        run(4'd14, 32'h700, 9, 2, 32'hFFFF_FFFE);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] c;
            logic [31:0] a, b, imm;
            c = 4'($urandom);
            a = $urandom;
            b = ($urandom % 4 == 0) ? a : $urandom;
            if ($urandom % 8 == 0) b = {~a[31], a[30:0]};
            imm = $urandom;
            if ($urandom % 2 == 0) imm = {{20{imm[11]}}, imm[11:0]};
            run(c, $urandom & 32'hFFFF_FFFC, a, b, imm);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule